// File: doc/BRIEF.md
# NAND Sector Hamming Code Generator and Checker

This block builds a 24-bit single-error-correcting parity code for one flash sector while the sector's bytes pass through it, one byte per clock. Every data bit in the sector has a 12-bit position: the byte offset in the upper nine bits and the bit index in the lower three. For each of those twelve position bits the block keeps two parities. The "odd" parity covers the data bits whose position bit is 1. The "even" parity covers the data bits whose position bit is 0. The finished code is the inverse of {odd[11:0], even[11:0]}. Because of the inversion, a sector of all 0xFF bytes yields 0xFFFFFF. An erased page therefore carries a matching code without any special case.

When a sector has been read back from flash, the controller presents the code stored beside it and raises a compare request. The block XORs the stored code with the code it computed and sorts the difference into four outcomes: clean, a single data bit to fix, an error inside the stored code only, or uncorrectable. For a fixable error it reports the byte offset and a one-hot mask of the bit to flip. The caller applies the flip to its own buffer.

A small sequencer with three states governs the stream. IDLE waits for a start strobe. FILL accepts bytes. SEALED holds a finished code. The transitions are as follows. START (start strobe, taken from any state) goes to FILL. LAST_BYTE (the final byte of the sector is accepted in FILL) goes to SEALED. CONSUME (an accepted compare in SEALED) returns to IDLE and clears the parity state.

Top module: `nand_hamming_ecc`

## Requirements
- R1: `ecc_code_o` equals the bitwise inverse of {odd[11:0], even[11:0]}. Code byte 0 is bits 7:0. Position bit k of data bit b in byte i comes from the 12-bit value i*8+b.
- R2: A start strobe clears all parity state and the byte count in any state. A byte presented with `valid_i` in the same cycle as the start strobe is taken as offset 0.
- R3: `code_valid_o` rises in the cycle after the SECTOR_BYTES-th accepted byte. While `code_valid_o` is high, bytes presented without a start strobe leave `ecc_code_o` unchanged.
- R4: A sector made entirely of 0xFF bytes produces code 0xFFFFFF.
- R5: A compare request is accepted only while `code_valid_o` is high and no start strobe is present. `result_valid_o` is high for exactly the one cycle after an accepted request. A request made in any other state produces no result.
- R6: A difference of zero gives status 2'b00 (clean), with offset and mask zero.
- R7: If diff[11:0] XOR diff[23:12] equals 0xFFF and diff[23:15] is below SECTOR_BYTES, the status is 2'b01 (fix). In that case the offset is diff[23:15] and the mask is 1 shifted left by diff[14:12].
- R8: A difference that passes the complement test but points at an offset of SECTOR_BYTES or more gives status 2'b11 (uncorrectable).
- R9: A difference with exactly one bit set gives status 2'b10 (code-only error), with offset and mask zero.
- R10: Any other nonzero difference gives status 2'b11, with offset and mask zero.
- R11: An accepted compare empties the parity state. In the next cycle, `code_valid_o` is low and `ecc_code_o` reads 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new sector; clears the accumulation |
| valid_i | input | 1 | `data_i` carries a sector byte this cycle |
| data_i | input | 8 | Sector byte |
| cmp_i | input | 1 | Compare request |
| stored_code_i | input | 24 | Code read from the spare area, byte 0 in bits 7:0 |
| ecc_code_o | output | 24 | Computed code, byte 0 in bits 7:0 |
| code_valid_o | output | 1 | A full sector has been accumulated |
| result_valid_o | output | 1 | One-cycle strobe: the result outputs were just updated |
| status_o | output | 2 | 00 clean, 01 fix, 10 code-only error, 11 uncorrectable |
| err_offset_o | output | 9 | Byte offset to repair (status 01 only) |
| err_mask_o | output | 8 | One-hot bit to flip (status 01 only) |

## Verification
The bench targets single-bit faults at the extremes of the position space: offset 0 bit 0, where the upper half of the difference is all zeros, and offset 511 bit 7, where the lower half is all zeros. A design that swapped the even and odd halves, or that dropped the inversion, would report a wrong location or miss the match on an erased page. A shortened-sector instance is driven with faults at the last legal offset and one offset past it, which catches a range check that is off by one or missing. Single-bit code faults at both ends of the code, and a two-bit difference, check the ordering of the classifier. Compares issued while idle or mid-sector, bytes sent after sealing, and a restart in mid-sector show whether the sequencer lets stray strobes reach the parity state or the result outputs.

// File: rtl/nhe_pkg.sv
package nhe_pkg;

    localparam int BIT_W   = 3;
    localparam int OFS_W   = 9;
    localparam int FIELD_W = OFS_W + BIT_W;
    localparam int CODE_W  = 2 * FIELD_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FILL   = 2'b01,
        ST_SEALED = 2'b10
    } sect_state_t;

    typedef enum logic [1:0] {
        CHK_CLEAN     = 2'b00,
        CHK_FIXED     = 2'b01,
        CHK_CODE_ONLY = 2'b10,
        CHK_FATAL     = 2'b11
    } chk_status_t;

    // Bits of a byte whose bit-index has bit k set.
    function automatic logic [7:0] lane_mask(input int k);
        logic [7:0] m;
        m = '0;
        for (int b = 0; b < 8; b++) begin
            m[b] = ((b >> k) & 1) == 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/nhe_seq_ctrl.sv
module nhe_seq_ctrl
    import nhe_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic             cmp_i,
    output logic             take_o,
    output logic             clear_o,
    output logic             cmp_fire_o,
    output logic             sealed_o,
    output logic [OFS_W-1:0] byte_ofs_o
);

    localparam int CNT_W = $clog2(SECTOR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SECTOR_BYTES - 1);

    sect_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state logic (START, LAST_BYTE, CONSUME)
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_FILL;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_FILL:   if (valid_i && cnt_q == LAST) state_d = ST_SEALED;
                ST_SEALED: if (cmp_i) state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = valid_i ? CNT_W'(1) : '0;
        end else if (state_q == ST_FILL && valid_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end else if (state_q == ST_SEALED && cmp_i) begin
            cnt_d = '0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        take_o     = valid_i && (start_i || state_q == ST_FILL);
        cmp_fire_o = cmp_i && !start_i && state_q == ST_SEALED;
        clear_o    = start_i || cmp_fire_o;
        sealed_o   = state_q == ST_SEALED;
        byte_ofs_o = start_i ? '0 : OFS_W'(cnt_q);
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SECTOR_BYTES));

    assert_seal_on_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sealed_o) |-> $past(valid_i));

endmodule

// File: rtl/nhe_parity_acc.sv
module nhe_parity_acc
    import nhe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic               clear_i,
    input  logic [7:0]         data_i,
    input  logic [OFS_W-1:0]   ofs_i,
    output logic [FIELD_W-1:0] even_o,
    output logic [FIELD_W-1:0] odd_o
);

    logic [FIELD_W-1:0] even_c, odd_c;
    logic               byte_par;

    assign byte_par = ^data_i;

    for (genvar k = 0; k < FIELD_W; k++) begin : g_lane
        if (k < BIT_W) begin : g_bitpos
            localparam logic [7:0] SEL = lane_mask(k);
            assign odd_c[k]  = ^(data_i & SEL);
            assign even_c[k] = ^(data_i & ~SEL);
        end else begin : g_bytepos
            assign odd_c[k]  = ofs_i[k-BIT_W] & byte_par;
            assign even_c[k] = ~ofs_i[k-BIT_W] & byte_par;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_o <= '0;
            odd_o  <= '0;
        end else if (clear_i) begin
            even_o <= take_i ? even_c : '0;
            odd_o  <= take_i ? odd_c  : '0;
        end else if (take_i) begin
            even_o <= even_o ^ even_c;
            odd_o  <= odd_o ^ odd_c;
        end
    end

endmodule

// File: rtl/nhe_classify.sv
module nhe_classify
    import nhe_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] calc_i,
    input  logic [CODE_W-1:0] stored_i,
    output chk_status_t       status_o,
    output logic [OFS_W-1:0]  ofs_o,
    output logic [7:0]        mask_o
);

    logic [CODE_W-1:0] diff;
    logic              halves_comp, one_bit, in_range;
    logic [OFS_W-1:0]  fix_ofs;
    logic [BIT_W-1:0]  fix_bit;

    always_comb begin
        diff        = calc_i ^ stored_i;
        halves_comp = (diff[FIELD_W-1:0] ^ diff[CODE_W-1:FIELD_W]) == '1;
        one_bit     = (diff != '0) && ((diff & (diff - CODE_W'(1))) == '0);
        fix_ofs     = diff[CODE_W-1:FIELD_W+BIT_W];
        fix_bit     = diff[FIELD_W+BIT_W-1:FIELD_W];
        in_range    = int'(fix_ofs) < SECTOR_BYTES;

        status_o = CHK_FATAL;
        ofs_o    = '0;
        mask_o   = '0;
        if (diff == '0) begin
            status_o = CHK_CLEAN;
        end else if (halves_comp) begin
            if (in_range) begin
                status_o = CHK_FIXED;
                ofs_o    = fix_ofs;
                mask_o   = 8'(1) << fix_bit;
            end
        end else if (one_bit) begin
            status_o = CHK_CODE_ONLY;
        end
    end

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
    import nhe_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        valid_i,
    input  logic [7:0]  data_i,
    input  logic        cmp_i,
    input  logic [23:0] stored_code_i,
    output logic [23:0] ecc_code_o,
    output logic        code_valid_o,
    output logic        result_valid_o,
    output logic [1:0]  status_o,
    output logic [8:0]  err_offset_o,
    output logic [7:0]  err_mask_o
);

    logic               take, clear, cmp_fire, sealed;
    logic [OFS_W-1:0]   byte_ofs;
    logic [FIELD_W-1:0] even_par, odd_par;
    chk_status_t        cls_status;
    logic [OFS_W-1:0]   cls_ofs;
    logic [7:0]         cls_mask;
    logic [CODE_W-1:0]  calc_code;

    nhe_seq_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .valid_i   (valid_i),
        .cmp_i     (cmp_i),
        .take_o    (take),
        .clear_o   (clear),
        .cmp_fire_o(cmp_fire),
        .sealed_o  (sealed),
        .byte_ofs_o(byte_ofs)
    );

    nhe_parity_acc u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .clear_i(clear),
        .data_i (data_i),
        .ofs_i  (byte_ofs),
        .even_o (even_par),
        .odd_o  (odd_par)
    );

    assign calc_code = ~{odd_par, even_par};

    nhe_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
        .calc_i  (calc_code),
        .stored_i(stored_code_i),
        .status_o(cls_status),
        .ofs_o   (cls_ofs),
        .mask_o  (cls_mask)
    );

    chk_status_t      status_q;
    logic [OFS_W-1:0] ofs_q;
    logic [7:0]       mask_q;
    logic             rvalid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= CHK_CLEAN;
            ofs_q    <= '0;
            mask_q   <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= cmp_fire;
            if (cmp_fire) begin
                status_q <= cls_status;
                ofs_q    <= cls_ofs;
                mask_q   <= cls_mask;
            end
        end
    end

    assign ecc_code_o     = calc_code;
    assign code_valid_o   = sealed;
    assign result_valid_o = rvalid_q;
    assign status_o       = status_q;
    assign err_offset_o   = ofs_q;
    assign err_mask_o     = mask_q;

    assert_result_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> ($past(cmp_i) && $past(code_valid_o) && !$past(start_i)));

    assert_fix_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid_o && status_o == 2'b01) |-> $onehot(err_mask_o));

    assert_loc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid_o && status_o != 2'b01) |-> (err_offset_o == '0 && err_mask_o == '0));

    assert_sealed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid_o && !start_i && !cmp_i) |=> (code_valid_o && $stable(ecc_code_o)));

    assert_consume_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid_o && cmp_i && !start_i) |=> (!code_valid_o && ecc_code_o == 24'hFFFFFF));

endmodule

// File: tb/tb_nand_hamming_ecc.sv
module tb_nand_hamming_ecc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        cmp_i = 1'b0;
    logic [23:0] stored_code_i = '0;

    logic [23:0] code, code_s;
    logic        cvalid, cvalid_s, rvalid, rvalid_s;
    logic [1:0]  status, status_s;
    logic [8:0]  ofs, ofs_s;
    logic [7:0]  mask, mask_s;

    int checks = 0;
    int fails  = 0;

    localparam int ERASED = -1;

    always #5 clk = ~clk;

    nand_hamming_ecc #(.SECTOR_BYTES(512)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .cmp_i(cmp_i), .stored_code_i(stored_code_i),
        .ecc_code_o(code), .code_valid_o(cvalid), .result_valid_o(rvalid),
        .status_o(status), .err_offset_o(ofs), .err_mask_o(mask)
    );

    nand_hamming_ecc #(.SECTOR_BYTES(64)) dut_short (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .cmp_i(cmp_i), .stored_code_i(stored_code_i),
        .ecc_code_o(code_s), .code_valid_o(cvalid_s), .result_valid_o(rvalid_s),
        .status_o(status_s), .err_offset_o(ofs_s), .err_mask_o(mask_s)
    );

    // {seed, flip, status, offset, mask}
    localparam int NVEC = 9;
    localparam logic [50:0] VEC [NVEC] = '{
        {8'd1,  24'h000000, 2'b00, 9'd0,   8'h00},
        {8'd2,  24'h02BFD4, 2'b01, 9'd5,   8'h08},
        {8'd3,  24'hFFF000, 2'b01, 9'd511, 8'h80},
        {8'd4,  24'h000FFF, 2'b01, 9'd0,   8'h01},
        {8'd5,  24'h000001, 2'b10, 9'd0,   8'h00},
        {8'd6,  24'h800000, 2'b10, 9'd0,   8'h00},
        {8'd7,  24'h000003, 2'b11, 9'd0,   8'h00},
        {8'd8,  24'h123456, 2'b11, 9'd0,   8'h00},
        {8'd9,  24'h8027FD, 2'b01, 9'd256, 8'h04}
    };

    function automatic logic [7:0] dbyte(int seed, int i);
        if (seed < 0) return 8'hFF;
        return 8'((i * 29 + seed * 53 + i / 7) ^ (seed * 3));
    endfunction

    function automatic logic [23:0] ref_code(int seed, int n);
        logic [11:0] ev, od, a;
        logic [7:0]  d;
        ev = '0;
        od = '0;
        for (int i = 0; i < n; i++) begin
            d = dbyte(seed, i);
            for (int b = 0; b < 8; b++) begin
                if (d[b]) begin
                    a = 12'(i * 8 + b);
                    for (int k = 0; k < 12; k++) begin
                        if (a[k]) od[k] = ~od[k];
                        else      ev[k] = ~ev[k];
                    end
                end
            end
        end
        return ~{od, ev};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Streams n bytes; start rides with byte 0. Ends at a negedge with
    // the last byte already taken.
    task automatic send(int seed, int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 5) == 2) begin
                @(negedge clk);
                start_i = 1'b0;
                valid_i = 1'b0;
            end
            @(negedge clk);
            start_i = (i == 0);
            valid_i = 1'b1;
            data_i  = dbyte(seed, i);
        end
        @(negedge clk);
        start_i = 1'b0;
        valid_i = 1'b0;
    endtask

    // Issues a compare at the current negedge; returns one cycle later.
    task automatic compare(logic [23:0] stored);
        cmp_i = 1'b1;
        stored_code_i = stored;
        @(negedge clk);
        cmp_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [23:0] exp_code, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R1 reset code", 32'(code), 32'hFFFFFF);
        check("R3 reset code_valid", 32'(cvalid), 32'd0);
        check("R5 reset result_valid", 32'(rvalid), 32'd0);
        check("R6 reset status", 32'(status), 32'd0);

        // R5: compare while idle gives no result
        compare(24'h0);
        check("R5 idle compare ignored", 32'(rvalid), 32'd0);

        // R4: erased sector
        send(ERASED, 512, 1'b0);
        check("R4 erased code", 32'(code), 32'hFFFFFF);
        check("R3 erased sealed", 32'(cvalid), 32'd1);
        compare(24'hFFFFFF);
        check("R4 erased compare status", 32'(status), 32'd0);
        check("R5 erased result_valid", 32'(rvalid), 32'd1);
        @(negedge clk);
        check("R5 result pulse one cycle", 32'(rvalid), 32'd0);

        // R2: partial sector, mid-fill compare, then restart
        send(30, 200, 1'b0);
        check("R3 partial not sealed", 32'(cvalid), 32'd0);
        compare(24'h0);
        check("R5 fill compare ignored", 32'(rvalid), 32'd0);
        send(31, 512, 1'b1);
        exp_code = ref_code(31, 512);
        check("R2 restart code", 32'(code), 32'(exp_code));
        check("R3 restart sealed", 32'(cvalid), 32'd1);

        // R3: bytes after sealing are ignored
        held = code;
        for (int i = 0; i < 10; i++) begin
            valid_i = 1'b1;
            data_i  = 8'(i * 17 + 1);
            @(negedge clk);
        end
        valid_i = 1'b0;
        check("R3 sealed ignores bytes code", 32'(code), 32'(held));
        check("R3 sealed ignores bytes valid", 32'(cvalid), 32'd1);

        // R8 / R7 on the 64-byte instance
        begin
            logic [23:0] sflip [4];
            logic [1:0]  sst   [4];
            sflip[0] = 24'h051FAE; sst[0] = 2'b01;
            sflip[1] = 24'h1FEE01; sst[1] = 2'b01;
            sflip[2] = 24'h200DFF; sst[2] = 2'b11;
            sflip[3] = 24'h320CDF; sst[3] = 2'b11;
            for (int t = 0; t < 4; t++) begin
                send(40 + t, 64, 1'b0);
                exp_code = ref_code(40 + t, 64);
                check("R1 short code", 32'(code_s), 32'(exp_code));
                check("R3 long not sealed", 32'(cvalid), 32'd0);
                compare(exp_code ^ sflip[t]);
                check("R8 short status", 32'(status_s), 32'(sst[t]));
                check("R5 long ignores compare", 32'(rvalid), 32'd0);
                if (sst[t] == 2'b11) begin
                    check("R8 short mask zero", 32'(mask_s), 32'd0);
                end
            end
        end

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0]  seed;
            logic [23:0] flip;
            logic [1:0]  est;
            logic [8:0]  eofs;
            logic [7:0]  emask;
            {seed, flip, est, eofs, emask} = VEC[v];
            send(int'(seed), 512, v[0]);
            exp_code = ref_code(int'(seed), 512);
            check("R1 sector code", 32'(code), 32'(exp_code));
            check("R3 code_valid", 32'(cvalid), 32'd1);
            compare(exp_code ^ flip);
            check("R5 result_valid", 32'(rvalid), 32'd1);
            check("R6 R7 R9 R10 status", 32'(status), 32'(est));
            check("R7 offset", 32'(ofs), 32'(eofs));
            check("R7 mask", 32'(mask), 32'(emask));
            check("R11 cleared code", 32'(code), 32'hFFFFFF);
            check("R11 cleared valid", 32'(cvalid), 32'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule